// File: doc/BRIEF.md
# Dual-Select SPI Configuration and FIFO Port

This block is the host-facing serial port of a radio transceiver. A host SPI master reaches two separate resources through two active-low chip selects that share one clock, one MOSI line and one MISO line. The configuration select opens a small register file that uses addressed transactions. The data select opens a byte FIFO that has no address phase. Each data-select low period carries exactly one byte, and the rising edge of that select commits the byte and moves the FIFO pointer on by one.

The FIFO sits between the host and the radio datapath. When the direction input marks transmit, SPI bytes are pushed and the radio drains them through a valid/ready output stream. When it marks receive, the radio fills the FIFO through a valid/ready input stream and the host pops bytes over SPI. Two level interrupts tell the host whether the FIFO holds data and whether it is full, so the host can pace its transfers. Sticky flags record a host write to a full FIFO and a host read from an empty one. All SPI inputs are oversampled by the system clock through a parameterised synchroniser, so SCK must run well below the system clock; the bench uses ten system clocks per SCK period.

Stream rules: a beat moves on a rising `clk` edge where valid and ready are both high. `ff_out_valid` stays high and `ff_out_data` stays stable until that beat is taken. `ff_in_ready` depends only on FIFO state, mode and direction, never on `ff_in_valid`.

Top module: `dual_select_spi_port`

## Requirements
- R1: SPI mode 0, MSB first. MOSI is sampled on rising SCK. MISO changes only after falling SCK, and the MSB of a returned byte is valid before the first rising edge of that byte.
- R2: With `cs_cfg_n` low, a byte with bit 7 = 0 is a write address (bits 6:0). The next byte is stored into that register, and any further bytes before the select rises are ignored. Register n appears on `cfg_regs[8n+7:8n]`; 32 registers sit at addresses 0 to 31, and all reset to 0.
- R3: A byte with bit 7 = 1 is a read address. The register contents are shifted out on MISO during the following byte. Addresses 32 to 127 read as 0, and writes to them change nothing.
- R4: Once a read has started, every further byte received in the same select period is taken as the next read address (bit 7 ignored), so a run of addresses returns a run of register values, each one byte late.
- R5: The FIFO path responds only when `cs_dat_n` is low, `cs_cfg_n` is high and `op_mode` is 2'b01 or 2'b10. With `op_mode` 2'b00 or 2'b11, data-select traffic and both streams are ignored.
- R6: A FIFO byte is committed at the rising edge of `cs_dat_n` only if exactly 8 rising SCK edges occurred while it was low. Shorter or longer frames move no data.
- R7: Transmit (`tx_dir`=1): committed SPI bytes are pushed, and the FIFO drains in order on `ff_out_*`. `ff_out_valid` is high exactly when the FIFO is non-empty.
- R8: Receive (`tx_dir`=0): `ff_in_ready` is high while the FIFO is not full. Each SPI frame returns the oldest byte, sampled at the falling edge of the select, and pops it.
- R9: `irq_avail` is high when the FIFO holds at least one byte. `irq_full` is high when it holds 16 bytes.
- R10: A committed SPI write while the FIFO is full is dropped and sets `ovf_flag`, which stays high until reset.
- R11: A committed SPI read that finds the FIFO empty returns 0x00, pops nothing and sets `udf_flag`, which stays high until reset.
- R12: When both selects are low together, the configuration port handles the traffic and the FIFO is left unchanged.
- R13: After reset, the FIFO is empty, both interrupts and both flags are low, MISO is 0 and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cs_cfg_n | input | 1 | Configuration select, active low |
| cs_dat_n | input | 1 | FIFO data select, active low |
| op_mode | input | 2 | 00 continuous, 01 buffered, 10 packet, 11 standby |
| tx_dir | input | 1 | 1 = transmit (host fills), 0 = receive (radio fills) |
| ff_in_valid | input | 1 | Radio byte offered to the FIFO |
| ff_in_data | input | 8 | Radio byte |
| ff_in_ready | output | 1 | FIFO accepts a radio byte |
| ff_out_valid | output | 1 | FIFO byte offered to the radio |
| ff_out_data | output | 8 | Oldest FIFO byte |
| ff_out_ready | input | 1 | Radio takes the offered byte |
| irq_avail | output | 1 | FIFO non-empty |
| irq_full | output | 1 | FIFO full |
| ovf_flag | output | 1 | Sticky host-write-when-full flag |
| udf_flag | output | 1 | Sticky host-read-when-empty flag |
| cfg_regs | output | 256 | All configuration registers, register n at bits 8n+7:8n |

## Verification
The bench goes after the frame-length boundary. It sends 7-bit and 9-bit data frames between full ones; a design that counted bits modulo 8, or committed on every select edge, would push a stray byte or pop one the host never saw. It fills the FIFO to exactly 16 and writes once more, then drains it and reads once more. A wrong level or pointer wrap would show as an early `irq_full`, a corrupted order, or a missing `ovf_flag` or `udf_flag`. It also drives both selects low at once and uses the two modes that disable the FIFO. A design that let the FIFO path act there would change the interrupt state. A burst read across every register would expose an address pipeline that is off by one byte.

// File: rtl/dsspi_pkg.sv
package dsspi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_CONT = 2'b00,
    MODE_BUF  = 2'b01,
    MODE_PKT  = 2'b10,
    MODE_STBY = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    CST_ADDR,
    CST_WDATA,
    CST_WDONE,
    CST_RDSTR
  } cfg_st_e;

  function automatic logic fifo_mode(input logic [1:0] m);
    return (m == MODE_BUF) || (m == MODE_PKT);
  endfunction
endpackage

// File: rtl/dsspi_frontend.sv
module dsspi_frontend #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       cs_cfg_n,
  input  logic       cs_dat_n,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  input  logic       load_hold,
  output logic       cfg_act,
  output logic       dat_act,
  output logic       cfg_start,
  output logic       dat_start,
  output logic       dat_end,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [3:0] rise_cnt,
  output logic       miso
);
  logic [SYNC-1:0] sck_q, mosi_q, ccfg_q, cdat_q;
  logic sck_d, ccfg_d, cdat_d;
  logic sck_s, mosi_s, ccfg_s, cdat_s;
  logic rise, fall, any_act, start;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sr, tx_sr;
  logic hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      ccfg_q <= '1;
      cdat_q <= '1;
      sck_d  <= 1'b0;
      ccfg_d <= 1'b1;
      cdat_d <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC-2:0], sck};
      mosi_q <= {mosi_q[SYNC-2:0], mosi};
      ccfg_q <= {ccfg_q[SYNC-2:0], cs_cfg_n};
      cdat_q <= {cdat_q[SYNC-2:0], cs_dat_n};
      sck_d  <= sck_s;
      ccfg_d <= ccfg_s;
      cdat_d <= cdat_s;
    end
  end

  assign sck_s     = sck_q[SYNC-1];
  assign mosi_s    = mosi_q[SYNC-1];
  assign ccfg_s    = ccfg_q[SYNC-1];
  assign cdat_s    = cdat_q[SYNC-1];
  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  assign cfg_act   = ~ccfg_s;
  assign dat_act   = ~cdat_s;
  assign cfg_start = ccfg_d & ~ccfg_s;
  assign dat_start = cdat_d & ~cdat_s;
  assign dat_end   = ~cdat_d & cdat_s;
  assign any_act   = cfg_act | dat_act;
  assign start     = cfg_start | dat_start;

  // receive shifter and edge counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rise_cnt  <= '0;
      rx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!any_act || start) begin
        bit_cnt  <= '0;
        rise_cnt <= '0;
      end else if (rise) begin
        rx_sr   <= {rx_sr[6:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (rise_cnt != 4'hF) rise_cnt <= rise_cnt + 4'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr[6:0], mosi_s};
        end
      end
    end
  end

  // transmit shifter: a mid-frame load survives the falling edge that follows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      hold  <= 1'b0;
    end else if (load_en) begin
      tx_sr <= load_byte;
      hold  <= load_hold;
    end else if (!any_act) begin
      tx_sr <= '0;
      hold  <= 1'b0;
    end else if (fall) begin
      if (hold) hold <= 1'b0;
      else      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  assign miso = tx_sr[7];

  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cnt == 4'hF) |=> (rise_cnt == 4'hF) || (rise_cnt == 4'h0));
  assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act && !fall && !load_en) |=> $stable(tx_sr));
endmodule

// File: rtl/dsspi_cfgregs.sv
module dsspi_cfgregs #(
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_act,
  input  logic              cfg_start,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              load_en,
  output logic [7:0]        load_byte,
  output logic [NREG*8-1:0] regs_flat
);
  import dsspi_pkg::*;
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  cfg_st_e    st;
  logic [6:0] wr_addr;
  logic [7:0] mem [NREG];
  logic [7:0] rd_data;
  logic       wr_en, rd_req, in_byte;

  assign in_byte = cfg_act & byte_done;
  assign wr_en   = in_byte && (st == CST_WDATA) && (int'(wr_addr) < NREG);
  assign rd_req  = in_byte && ((st == CST_ADDR && rx_byte[7]) || st == CST_RDSTR);

  always_comb begin
    rd_data = '0;
    if (int'(rx_byte[6:0]) < NREG) rd_data = mem[rx_byte[AW-1:0]];
  end

  assign load_en   = cfg_start | rd_req;
  assign load_byte = cfg_start ? 8'h00 : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CST_ADDR;
      wr_addr <= '0;
    end else if (!cfg_act) begin
      st <= CST_ADDR;
    end else if (byte_done) begin
      case (st)
        CST_ADDR: begin
          wr_addr <= rx_byte[6:0];
          st      <= rx_byte[7] ? CST_RDSTR : CST_WDATA;
        end
        CST_WDATA: st <= CST_WDONE;
        default:   st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr[AW-1:0]] <= rx_byte;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = mem[g];
  end

  assert_idle_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_act |=> (st == CST_ADDR));
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/dsspi_fifo.sv
module dsspi_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= push_data;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = mem[rp];
  assign empty = (count == '0);
  assign full  = (int'(count) == DEPTH);

  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(count));
endmodule

// File: rtl/dual_select_spi_port.sv
module dual_select_spi_port #(
  parameter int NREG  = 32,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic              cs_cfg_n,
  input  logic              cs_dat_n,
  input  logic [1:0]        op_mode,
  input  logic              tx_dir,
  input  logic              ff_in_valid,
  input  logic [7:0]        ff_in_data,
  output logic              ff_in_ready,
  output logic              ff_out_valid,
  output logic [7:0]        ff_out_data,
  input  logic              ff_out_ready,
  output logic              irq_avail,
  output logic              irq_full,
  output logic              ovf_flag,
  output logic              udf_flag,
  output logic [NREG*8-1:0] cfg_regs
);
  import dsspi_pkg::*;

  logic cfg_act, dat_act, cfg_start, dat_start, dat_end, byte_done;
  logic [7:0] rx_byte;
  logic [3:0] rise_cnt;
  logic fe_load_en, fe_hold;
  logic [7:0] fe_load_byte;
  logic cr_load_en;
  logic [7:0] cr_load_byte;
  logic ff_load_en;
  logic fifo_en, fifo_ok, was_empty, commit;
  logic host_push, host_pop, radio_push, radio_pop;
  logic f_full, f_empty;
  logic [7:0] f_head;

  assign fifo_en = fifo_mode(op_mode);

  dsspi_frontend #(.SYNC(SYNC)) u_fe (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi),
    .cs_cfg_n(cs_cfg_n), .cs_dat_n(cs_dat_n),
    .load_en(fe_load_en), .load_byte(fe_load_byte), .load_hold(fe_hold),
    .cfg_act(cfg_act), .dat_act(dat_act), .cfg_start(cfg_start),
    .dat_start(dat_start), .dat_end(dat_end), .byte_done(byte_done),
    .rx_byte(rx_byte), .rise_cnt(rise_cnt), .miso(miso)
  );

  dsspi_cfgregs #(.NREG(NREG)) u_cr (
    .clk(clk), .rst_n(rst_n), .cfg_act(cfg_act), .cfg_start(cfg_start),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .load_en(cr_load_en), .load_byte(cr_load_byte), .regs_flat(cfg_regs)
  );

  dsspi_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_ff (
    .clk(clk), .rst_n(rst_n),
    .push(host_push | radio_push),
    .push_data(tx_dir ? rx_byte : ff_in_data),
    .pop(host_pop | radio_pop),
    .head(f_head), .full(f_full), .empty(f_empty)
  );

  // MISO source: configuration port has priority over the FIFO path
  assign ff_load_en   = dat_start & fifo_en & ~cfg_act & ~tx_dir;
  assign fe_load_en   = cr_load_en | ff_load_en;
  assign fe_load_byte = cr_load_en ? cr_load_byte : (f_empty ? 8'h00 : f_head);
  assign fe_hold      = cr_load_en & ~cfg_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_ok   <= 1'b0;
      was_empty <= 1'b1;
    end else if (dat_start) begin
      fifo_ok   <= fifo_en & ~cfg_act;
      was_empty <= f_empty;
    end else if (cfg_act) begin
      fifo_ok <= 1'b0;
    end
  end

  assign commit     = dat_end & fifo_ok & fifo_en & ~cfg_act & (rise_cnt == 4'd8);
  assign host_push  = commit & tx_dir & ~f_full;
  assign host_pop   = commit & ~tx_dir & ~was_empty;
  assign ff_in_ready  = fifo_en & ~tx_dir & ~f_full;
  assign radio_push   = ff_in_valid & ff_in_ready;
  assign ff_out_valid = fifo_en & tx_dir & ~f_empty;
  assign ff_out_data  = f_head;
  assign radio_pop    = ff_out_valid & ff_out_ready;
  assign irq_avail    = ~f_empty;
  assign irq_full     = f_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (commit & tx_dir & f_full)     ovf_flag <= 1'b1;
      if (commit & ~tx_dir & was_empty) udf_flag <= 1'b1;
    end
  end

  assert_cfg_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_act |-> !(host_push || host_pop));
  assert_mode_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !(host_push || host_pop || radio_push || radio_pop));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  assert_udf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);
  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> !ff_in_ready);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_out_valid && !ff_out_ready && !host_push && $stable(op_mode) && $stable(tx_dir))
      |=> ff_out_valid && $stable(ff_out_data));
endmodule

// File: tb/sim_dual_select_spi_port.sv
module sim_dual_select_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_cfg_n = 1'b1, cs_dat_n = 1'b1;
  logic [1:0] op_mode = 2'b00;
  logic tx_dir = 1'b1;
  logic ff_in_valid = 1'b0, ff_out_ready = 1'b0;
  logic [7:0] ff_in_data = 8'h00;
  logic miso, ff_in_ready, ff_out_valid, irq_avail, irq_full, ovf_flag, udf_flag;
  logic [7:0] ff_out_data;
  logic [255:0] cfg_regs;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_select_spi_port u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .miso(miso),
    .cs_cfg_n(cs_cfg_n), .cs_dat_n(cs_dat_n), .op_mode(op_mode), .tx_dir(tx_dir),
    .ff_in_valid(ff_in_valid), .ff_in_data(ff_in_data), .ff_in_ready(ff_in_ready),
    .ff_out_valid(ff_out_valid), .ff_out_data(ff_out_data), .ff_out_ready(ff_out_ready),
    .irq_avail(irq_avail), .irq_full(irq_full), .ovf_flag(ovf_flag),
    .udf_flag(udf_flag), .cfg_regs(cfg_regs)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] qv(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one SPI mode 0 frame body; sample MISO just before each rising edge
  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7 - (i % 8)];
      tick(5);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      tick(5);
      sck = 1'b0;
    end
  endtask

  task automatic cfg_on();  cs_cfg_n = 1'b0; tick(5); endtask
  task automatic cfg_off(); tick(3); cs_cfg_n = 1'b1; tick(6); endtask

  task automatic cfg_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    cfg_on(); xfer({1'b0, a}, 8, r); xfer(d, 8, r); cfg_off();
  endtask

  task automatic cfg_read(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    cfg_on(); xfer({1'b1, a}, 8, r); xfer(8'h00, 8, d); cfg_off();
  endtask

  task automatic dat_frame(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    cs_dat_n = 1'b0; tick(5); xfer(tx, nbits, rx); tick(3); cs_dat_n = 1'b1; tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    tick(4); rst_n = 1'b1; tick(4);

    // R13 reset state
    chk("R13 miso", miso, 0);
    chk("R13 irq_avail", irq_avail, 0);
    chk("R13 irq_full", irq_full, 0);
    chk("R13 ovf", ovf_flag, 0);
    chk("R13 udf", udf_flag, 0);
    chk("R13 regs", (cfg_regs == '0), 1);

    // R2 sweep: write every register, with a trailing byte that must be ignored
    for (int a = 0; a < 32; a++) begin
      cfg_on(); xfer({1'b0, 7'(a)}, 8, r); xfer(pat(a), 8, r); xfer(~pat(a), 8, r); cfg_off();
    end
    for (int a = 0; a < 32; a++) chk("R2 cfg_regs lane", cfg_regs[a*8 +: 8], pat(a));

    // R1 R3 single reads
    for (int a = 0; a < 32; a++) begin
      cfg_read(7'(a), r);
      chk("R1 R3 read", r, pat(a));
    end

    // R3 unmapped addresses: write ignored, read zero
    cfg_write(7'h45, 8'hAA);
    cfg_write(7'h20, 8'h55);
    cfg_read(7'h45, r); chk("R3 unmapped read 0x45", r, 0);
    cfg_read(7'h7F, r); chk("R3 unmapped read 0x7F", r, 0);
    for (int a = 0; a < 32; a++) chk("R3 no alias write", cfg_regs[a*8 +: 8], pat(a));

    // R4 burst read of every register
    cfg_on();
    xfer(8'h80, 8, r);
    for (int a = 1; a < 32; a++) begin
      xfer(8'h80 | 8'(a), 8, r);
      chk("R4 burst", r, pat(a - 1));
    end
    xfer(8'h00, 8, r); chk("R4 burst last", r, pat(31));
    cfg_off();

    // R5 FIFO path ignored in continuous and standby modes
    tx_dir = 1'b1;
    op_mode = 2'b00; dat_frame(8'h11, 8, r); chk("R5 mode 00 ignored", irq_avail, 0);
    op_mode = 2'b11; dat_frame(8'h22, 8, r); chk("R5 mode 11 ignored", irq_avail, 0);
    chk("R5 no stream in mode 11", ff_out_valid, 0);

    // R6 frame length boundaries
    op_mode = 2'b01;
    dat_frame(8'h33, 7, r); chk("R6 7-bit frame dropped", irq_avail, 0);
    dat_frame(8'h44, 9, r); chk("R6 9-bit frame dropped", irq_avail, 0);

    // R12 both selects low: register written, FIFO untouched
    cs_cfg_n = 1'b0; cs_dat_n = 1'b0; tick(5);
    xfer(8'h05, 8, r); xfer(8'h3C, 8, r);
    tick(3); cs_dat_n = 1'b1; cs_cfg_n = 1'b1; tick(6);
    chk("R12 cfg took write", cfg_regs[5*8 +: 8], 8'h3C);
    chk("R12 fifo untouched", irq_avail, 0);

    // R7 R9 R10 fill to depth in transmit direction
    for (int i = 0; i < 16; i++) begin
      dat_frame(qv(i), 8, r);
      chk("R9 irq_avail while filling", irq_avail, 1);
      chk("R9 irq_full level", irq_full, (i == 15) ? 1 : 0);
    end
    chk("R10 ovf before overflow", ovf_flag, 0);
    dat_frame(8'hEE, 8, r);
    chk("R10 ovf set", ovf_flag, 1);
    chk("R10 still full", irq_full, 1);

    // R7 drain with back-pressure
    for (int i = 0; i < 16; i++) begin
      chk("R7 out valid", ff_out_valid, 1);
      chk("R7 out order", ff_out_data, qv(i));
      tick(2);
      chk("R7 held under back-pressure", ff_out_data, qv(i));
      ff_out_ready = 1'b1; tick(1); ff_out_ready = 1'b0;
    end
    chk("R7 empty after drain", ff_out_valid, 0);
    chk("R9 irq_avail clear", irq_avail, 0);
    chk("R10 ovf sticky", ovf_flag, 1);

    // R8 receive direction in packet mode
    op_mode = 2'b10; tx_dir = 1'b0; tick(1);
    for (int i = 0; i < 16; i++) begin
      chk("R8 in ready", ff_in_ready, 1);
      ff_in_data = qv(i + 40); ff_in_valid = 1'b1; tick(1); ff_in_valid = 1'b0;
    end
    chk("R8 ready low when full", ff_in_ready, 0);
    chk("R9 full in receive", irq_full, 1);
    chk("R8 out stream idle in receive", ff_out_valid, 0);
    dat_frame(8'h00, 7, r);
    chk("R6 short read leaves full", irq_full, 1);
    for (int i = 0; i < 16; i++) begin
      dat_frame(8'h00, 8, r);
      chk("R8 host read order", r, qv(i + 40));
    end
    chk("R9 empty after reads", irq_avail, 0);
    chk("R11 udf before underflow", udf_flag, 0);
    dat_frame(8'h00, 8, r);
    chk("R11 empty read data", r, 0);
    chk("R11 udf set", udf_flag, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule